// File: doc/BRIEF.md
# DMA Bus Hold Handshake Sequencer

This block obtains ownership of the system bus on behalf of a DMA controller before any transfer state runs, and hands the bus back afterwards. A request carries a channel number. The sequencer raises a hold request toward the host processor. It waits for the host's hold-acknowledge, then steps through the transfer states S1, S2 and S4. Finally it runs a timed release before it drops the hold line again. All timing runs on one fast clock. Three single-cycle enables stand in for the slower clocks: one for the DMA state clock, one for the oscillator clock and one for the processor clock.

The channel group sets how long the block stays in S0 after the acknowledge is seen. The upper group (channels 5 to 7) moves on at once. The lower group (channels 0 to 3) spends three extra S0 periods there, because those channels cascade through the upper group. Channel 4 is the cascade slot and is refused. The release waits out full oscillator periods, which are stretched while refresh is busy, and then full processor periods. The hold output only changes on processor-clock enables. When the acknowledge rises while a memory row strobe is active, the block drives a pulse that forces that strobe inactive.

Top module: `busgrant_seq`

## Requirements
- R1: From idle, with `hold_o` low, a cycle with `req_valid` high and `req_chan` not 4 moves the block to S0 at the next clock edge. The `state_code` encoding is 0 for idle (also shown during release), 1 for S0, 2 for S1, 3 for S2 and 4 for S4. A request made outside idle, or while `hold_o` is high, is ignored.
- R2: For channels 5 to 7, the first cycle in S0 that has `dma_tick` and `hlda` both high moves the block to S1 at that clock edge.
- R3: For channels 0 to 3, the cycle in which the acknowledge is sampled (as in R2) keeps the block in S0. Three further `dma_tick` cycles follow in S0, and the third of them moves the block to S1.
- R4: `hold_o` changes only at edges where `proc_tick` is high. At such an edge it takes the value "sequencer not idle", which includes S0 through the release phase.
- R5: S1, S2 and S4 each last until the next `dma_tick`. Each such tick advances the state: S1 to S2, S2 to S4, and S4 to the release phase.
- R6: In the release phase, the block counts three `osc_tick` cycles that occur while `refresh_busy` is low. The first of these only opens a full period. After that it counts two `proc_tick` cycles, and then it returns to idle. A tick that falls while refresh is busy is not counted.
- R7: `ras_force_hi` is high, in the same cycle and combinationally, when `hlda` is high, `hlda` was low at the previous clock edge, and `ras_active` is high. It is low otherwise.
- R8: A request for channel 4, made in idle with `hold_o` low, leaves the state unchanged. It raises `chan_err` for exactly the following cycle. `chan_err` is low at all other times.
- R9: A clock edge with `rst_n` low returns the block to idle with `hold_o` low, `chan_err` low and the previous-acknowledge history cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_tick | input | 1 | One-cycle enable marking a DMA state-clock period |
| osc_tick | input | 1 | One-cycle enable marking an oscillator-clock period |
| proc_tick | input | 1 | One-cycle enable marking a processor-clock period |
| req_valid | input | 1 | Transfer request |
| req_chan | input | 3 | Requested channel number |
| hlda | input | 1 | Hold acknowledge from the host |
| ras_active | input | 1 | Memory row strobe currently active |
| refresh_busy | input | 1 | Refresh in progress; stalls the oscillator part of the release |
| hold_o | output | 1 | Hold request, synchronized to processor enables |
| state_code | output | 3 | Current state code (see R1) |
| ras_force_hi | output | 1 | Pulse forcing the row strobe inactive |
| chan_err | output | 1 | One-cycle flag for a refused cascade-channel request |

## Verification
The state code and `chan_err` are registered. Both are due one cycle after the edge that sampled the stimulus. `hold_o` is also registered, but it moves only at an edge where `proc_tick` is high. `ras_force_hi` is combinational and is due in the same cycle as the `hlda` rise. The bench drives inputs at the falling edge. At the next falling edge it advances its own requirement model once, using the inputs that the rising edge just used, and compares the registered outputs. It checks `ras_force_hi` one time step after the new inputs settle.

// File: rtl/busgrant_pkg.sv
// Shared types for the bus hold handshake sequencer.
// Assumes: state values 0..4 double as the external state code, except release.
package busgrant_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_S0   = 3'd1,
        ST_S1   = 3'd2,
        ST_S2   = 3'd3,
        ST_S4   = 3'd4,
        ST_REL  = 3'd5
    } bg_state_e;

    // Map the internal state to the code seen at the port; release reads as idle.
    function automatic logic [2:0] bg_state_code(bg_state_e s);
        return (s == ST_REL) ? 3'd0 : 3'(s);
    endfunction

endpackage

// File: rtl/bg_hold_sync.sv
// Holds the bus request in a register that updates only on processor-clock enables.
// Assumes: proc_tick is a one-cycle enable in the clk domain.
module bg_hold_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic proc_tick,
    input  logic hold_req,
    output logic hold_o
);

    logic hold_q;

    // Capture the request only at processor-clock boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (proc_tick) begin
            hold_q <= hold_req;
        end
    end

    assign hold_o = hold_q;

    // R4
    hold_proc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !proc_tick |=> $stable(hold_o));

endmodule

// File: rtl/bg_release_timer.sv
// Times the release: full oscillator periods, then full processor periods.
// Assumes: the first tick counted only opens a period, so N full periods need N+1 ticks.
module bg_release_timer #(
    parameter int OSC_PERIODS  = 2,
    parameter int PROC_PERIODS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic osc_tick,
    input  logic proc_tick,
    input  logic refresh_busy,
    output logic done
);

    localparam int OSC_LIM  = OSC_PERIODS + 1;
    localparam int PROC_LIM = PROC_PERIODS + 1;
    localparam int OW = $clog2(OSC_LIM + 1);
    localparam int PW = $clog2(PROC_LIM + 1);
    localparam logic [OW-1:0] OSC_MAX  = OW'(OSC_LIM);
    localparam logic [PW-1:0] PROC_MAX = PW'(PROC_LIM);

    logic [OW-1:0] osc_cnt;
    logic [PW-1:0] proc_cnt;
    logic          osc_full;

    assign osc_full = (osc_cnt == OSC_MAX);

    // Count oscillator ticks outside refresh, then processor ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            osc_cnt  <= '0;
            proc_cnt <= '0;
        end else begin
            if (osc_tick && !refresh_busy && !osc_full) begin
                osc_cnt <= osc_cnt + OW'(1);
            end
            if (osc_full && proc_tick && (proc_cnt != PROC_MAX)) begin
                proc_cnt <= proc_cnt + PW'(1);
            end
        end
    end

    assign done = (proc_cnt == PROC_MAX);

    // R6
    proc_after_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_cnt != '0) |-> osc_full);

    // R6
    refresh_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && refresh_busy) |=> (osc_cnt == $past(osc_cnt)) || !$past(active));

endmodule

// File: rtl/bg_ras_guard.sv
// Raises a force-high pulse for the row strobe on the acknowledge rising edge.
// Assumes: hlda is already synchronous to clk.
module bg_ras_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic hlda,
    input  logic ras_active,
    output logic ras_force_hi
);

    logic hlda_d;

    // Remember the acknowledge from the previous edge for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hlda_d <= 1'b0;
        end else begin
            hlda_d <= hlda;
        end
    end

    assign ras_force_hi = hlda && !hlda_d && ras_active;

    // R7
    ras_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ras_force_hi |=> !ras_force_hi);

endmodule

// File: rtl/bg_sequencer.sv
// Walks idle, S0 (with channel-group wait), S1, S2, S4 and release.
// Assumes: EXTRA_S0 >= 1; channels at or above UPPER_BASE skip the extra S0 states.
module bg_sequencer
    import busgrant_pkg::*;
#(
    parameter int CHAN_W       = 3,
    parameter int CASCADE_CHAN = 4,
    parameter int UPPER_BASE   = 5,
    parameter int EXTRA_S0     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_tick,
    input  logic              req_valid,
    input  logic [CHAN_W-1:0] req_chan,
    input  logic              hlda,
    input  logic              hold_o,
    input  logic              rel_done,
    output bg_state_e         state_o,
    output logic              chan_err
);

    localparam int WAIT_W = $clog2(EXTRA_S0 + 1);
    localparam logic [CHAN_W-1:0] CASC_C  = CHAN_W'(CASCADE_CHAN);
    localparam logic [CHAN_W-1:0] UPPER_C = CHAN_W'(UPPER_BASE);
    localparam logic [WAIT_W-1:0] EXTRA_C = WAIT_W'(EXTRA_S0);
    localparam logic [WAIT_W-1:0] ONE_C   = WAIT_W'(1);

    bg_state_e         state_q, state_d;
    logic [CHAN_W-1:0] chan_q, chan_d;
    logic              ack_q, ack_d;
    logic [WAIT_W-1:0] wait_q, wait_d;
    logic              err_q, err_d;
    logic              upper_grp;

    assign upper_grp = (chan_q >= UPPER_C);

    // Next-state decision for the handshake.
    always_comb begin
        state_d = state_q;
        chan_d  = chan_q;
        ack_d   = ack_q;
        wait_d  = wait_q;
        err_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && !hold_o) begin
                    if (req_chan == CASC_C) begin
                        err_d = 1'b1;
                    end else begin
                        state_d = ST_S0;
                        chan_d  = req_chan;
                        ack_d   = 1'b0;
                        wait_d  = '0;
                    end
                end
            end
            ST_S0: begin
                if (dma_tick) begin
                    if (!ack_q) begin
                        if (hlda) begin
                            if (upper_grp) begin
                                state_d = ST_S1;
                            end else begin
                                ack_d  = 1'b1;
                                wait_d = EXTRA_C;
                            end
                        end
                    end else if (wait_q <= ONE_C) begin
                        state_d = ST_S1;
                    end else begin
                        wait_d = wait_q - ONE_C;
                    end
                end
            end
            ST_S1:   if (dma_tick) state_d = ST_S2;
            ST_S2:   if (dma_tick) state_d = ST_S4;
            ST_S4:   if (dma_tick) state_d = ST_REL;
            ST_REL:  if (rel_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Register the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            chan_q  <= '0;
            ack_q   <= 1'b0;
            wait_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            chan_q  <= chan_d;
            ack_q   <= ack_d;
            wait_q  <= wait_d;
            err_q   <= err_d;
        end
    end

    assign state_o  = state_q;
    assign chan_err = err_q;

    // R2
    upper_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_S0 && dma_tick && hlda && !ack_q && upper_grp) |=> (state_q == ST_S1));

    // R3
    lower_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_S1 && $past(state_q) == ST_S0 && !upper_grp) |-> $past(ack_q));

    // R5
    xfer_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_tick && (state_q == ST_S1 || state_q == ST_S2 || state_q == ST_S4)) |=> $stable(state_q));

    // R8
    no_cascade_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (chan_q != CASC_C));

endmodule

// File: rtl/busgrant_seq.sv
// Top of the DMA bus hold handshake sequencer.
// Assumes: all tick inputs are one-cycle enables in the clk domain.
module busgrant_seq
    import busgrant_pkg::*;
#(
    parameter int CHAN_W       = 3,
    parameter int CASCADE_CHAN = 4,
    parameter int UPPER_BASE   = 5,
    parameter int EXTRA_S0     = 3,
    parameter int OSC_PERIODS  = 2,
    parameter int PROC_PERIODS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_tick,
    input  logic              osc_tick,
    input  logic              proc_tick,
    input  logic              req_valid,
    input  logic [CHAN_W-1:0] req_chan,
    input  logic              hlda,
    input  logic              ras_active,
    input  logic              refresh_busy,
    output logic              hold_o,
    output logic [2:0]        state_code,
    output logic              ras_force_hi,
    output logic              chan_err
);

    bg_state_e seq_state;
    logic      rel_done;
    logic      hold_req;

    bg_sequencer #(
        .CHAN_W      (CHAN_W),
        .CASCADE_CHAN(CASCADE_CHAN),
        .UPPER_BASE  (UPPER_BASE),
        .EXTRA_S0    (EXTRA_S0)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .dma_tick (dma_tick),
        .req_valid(req_valid),
        .req_chan (req_chan),
        .hlda     (hlda),
        .hold_o   (hold_o),
        .rel_done (rel_done),
        .state_o  (seq_state),
        .chan_err (chan_err)
    );

    bg_release_timer #(
        .OSC_PERIODS (OSC_PERIODS),
        .PROC_PERIODS(PROC_PERIODS)
    ) u_rel (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (seq_state == ST_REL),
        .osc_tick    (osc_tick),
        .proc_tick   (proc_tick),
        .refresh_busy(refresh_busy),
        .done        (rel_done)
    );

    assign hold_req = (seq_state != ST_IDLE);

    bg_hold_sync u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .proc_tick(proc_tick),
        .hold_req (hold_req),
        .hold_o   (hold_o)
    );

    bg_ras_guard u_ras (
        .clk         (clk),
        .rst_n       (rst_n),
        .hlda        (hlda),
        .ras_active  (ras_active),
        .ras_force_hi(ras_force_hi)
    );

    assign state_code = bg_state_code(seq_state);

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (state_code == 3'd0 && !hold_o && !chan_err));

endmodule

// File: tb/tb_busgrant_seq.sv
module tb_busgrant_seq;

    logic       clk = 1'b0;
    logic       rst_n, dma_tick, osc_tick, proc_tick, req_valid, hlda, ras_active, refresh_busy;
    logic [2:0] req_chan;
    logic       hold_o, ras_force_hi, chan_err;
    logic [2:0] state_code;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Requirement model: 0 idle, 1 S0, 2 S1, 3 S2, 4 S4, 5 release.
    int m_state, m_chan, m_ack, m_wait, m_osc, m_proc, m_hold, m_err, m_hlda_d;

    always #10 clk = ~clk;

    busgrant_seq dut (
        .clk(clk), .rst_n(rst_n), .dma_tick(dma_tick), .osc_tick(osc_tick),
        .proc_tick(proc_tick), .req_valid(req_valid), .req_chan(req_chan),
        .hlda(hlda), .ras_active(ras_active), .refresh_busy(refresh_busy),
        .hold_o(hold_o), .state_code(state_code), .ras_force_hi(ras_force_hi),
        .chan_err(chan_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    function automatic int exp_code(input int s);
        return (s == 5) ? 0 : s;
    endfunction

    function automatic string state_tag(input int s, input int ch);
        if (s == 0) return "R1";
        if (s == 1) return (ch >= 5) ? "R2" : "R3";
        if (s == 5) return "R6";
        return "R5";
    endfunction

    // Advance the model over one rising edge using the inputs it sampled.
    task automatic model_step();
        int n_state, n_chan, n_ack, n_wait, n_osc, n_proc, n_hold, n_err;
        if (!rst_n) begin
            m_state = 0; m_chan = 0; m_ack = 0; m_wait = 0;
            m_osc = 0; m_proc = 0; m_hold = 0; m_err = 0; m_hlda_d = 0;
            return;
        end
        n_state = m_state; n_chan = m_chan; n_ack = m_ack; n_wait = m_wait;
        n_osc = m_osc; n_proc = m_proc; n_hold = m_hold; n_err = 0;
        case (m_state)
            0: if (req_valid && m_hold == 0) begin
                   if (req_chan == 3'd4) n_err = 1;
                   else begin n_state = 1; n_chan = int'(req_chan); n_ack = 0; n_wait = 0; end
               end
            1: if (dma_tick) begin
                   if (m_ack == 0) begin
                       if (hlda) begin
                           if (m_chan >= 5) n_state = 2;
                           else begin n_ack = 1; n_wait = 3; end
                       end
                   end else if (m_wait <= 1) n_state = 2;
                   else n_wait = m_wait - 1;
               end
            2: if (dma_tick) n_state = 3;
            3: if (dma_tick) n_state = 4;
            4: if (dma_tick) n_state = 5;
            5: if (m_proc == 2) n_state = 0;
            default: n_state = 0;
        endcase
        if (m_state == 5) begin
            if (osc_tick && !refresh_busy && m_osc != 3) n_osc = m_osc + 1;
            if (m_osc == 3 && proc_tick && m_proc != 2) n_proc = m_proc + 1;
        end else begin
            n_osc = 0; n_proc = 0;
        end
        if (proc_tick) n_hold = (m_state != 0) ? 1 : 0;
        m_hlda_d = int'(hlda);
        m_state = n_state; m_chan = n_chan; m_ack = n_ack; m_wait = n_wait;
        m_osc = n_osc; m_proc = n_proc; m_hold = n_hold; m_err = n_err;
    endtask

    function automatic logic pick(input int den);
        return ($urandom % den) == 0;
    endfunction

    // Choose the inputs for the next rising edge by phase.
    task automatic drive_inputs();
        rst_n = !(cyc < 3 || (cyc >= 4000 && cyc < 4003));
        if (cyc < 4000) begin
            dma_tick = pick(3); osc_tick = pick(2); proc_tick = pick(4);
            refresh_busy = pick(4); req_valid = pick(4); req_chan = 3'($urandom % 8);
        end else if (cyc < 6000) begin
            dma_tick = 1'b1; osc_tick = 1'b1; proc_tick = pick(2);
            refresh_busy = ((cyc % 64) < 40); req_valid = 1'b1; req_chan = 3'((cyc / 7) % 8);
        end else begin
            dma_tick = pick(8); osc_tick = pick(3); proc_tick = pick(2);
            refresh_busy = pick(3); req_valid = pick(3); req_chan = 3'($urandom % 8);
        end
        if (hold_o) hlda = hlda | pick(3);
        else if (pick(2)) hlda = 1'b0;
        ras_active = pick(2);
    endtask

    initial begin
        void'($urandom(32'd20240613));
        rst_n = 1'b0; dma_tick = 0; osc_tick = 0; proc_tick = 0; req_valid = 0;
        req_chan = 0; hlda = 0; ras_active = 0; refresh_busy = 0;
        m_state = 0; m_chan = 0; m_ack = 0; m_wait = 0; m_osc = 0; m_proc = 0;
        m_hold = 0; m_err = 0; m_hlda_d = 0;
        for (int i = 0; i < 8000; i++) begin
            @(negedge clk);
            model_step();
            if (!rst_n) begin
                // R9: reset state
                chk("R9", int'(state_code), 0);
                chk("R9", int'(hold_o), 0);
                chk("R9", int'(chan_err), 0);
            end else begin
                chk(state_tag(m_state, m_chan), int'(state_code), exp_code(m_state));
                chk("R4", int'(hold_o), m_hold);
                chk("R8", int'(chan_err), m_err);
            end
            cyc++;
            drive_inputs();
            #1;
            // R7: force-high pulse on acknowledge rise with row strobe active
            chk("R7", int'(ras_force_hi), int'(hlda && m_hlda_d == 0 && ras_active));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule